// File: doc/BRIEF.md
# Predicate Register with Element Views

This block holds one vector predicate register of `NUM_BITS` flag bits and gives element-granular access to it. An element index selects a group of flag bits whose position and width depend on the element size given at run time and on the layout chosen at build time. In the compact layout (`PACKED = 1`), neighbouring bits belong to neighbouring elements, so every element owns exactly one bit. In the byte-per-bit layout (`PACKED = 0`), each flag bit shadows one byte of a vector register. An element of B bytes then owns B consecutive bits that start at index × B.

The block offers two whole-register commands: clear every flag, or set every flag. It also has one raw element write port and one raw element read port, and it always drives the whole register value out. The read port is combinational. It returns the element's bit group right-aligned and the element's truth value, which is the lowest bit of the group. Any access whose group would reach past the top of the register is flagged and has no effect. `NUM_BITS` must be at least 8.

Top module: `pred_reg_views`

## Requirements
- R1: With `PACKED = 1`, element i owns exactly bit i, whatever the value of `esize_i`.
- R2: With `PACKED = 0`, the element byte count is B = 1, 2, 4 or 8 for `esize_i` codes 0, 1, 2, 3, and element i owns bits i×B up to i×B+B−1.
- R3: For an in-range read, bit k of `rd_data_o` equals register bit base+k for every k below the group width, and all higher bits are 0. `rd_flag_o` equals the register bit at the group base.
- R4: An accepted write stores `wr_data_i[k]` into register bit base+k for every k below the group width on the next rising clock edge. Every other register bit keeps its value.
- R5: `clr_i` drives every register bit to 0 on the next edge and overrides every other command.
- R6: `set_i` without `clr_i` drives every register bit to 1 on the next edge.
- R7: A read whose group ends above bit `NUM_BITS`−1 raises `rd_err_o` and returns 0 on `rd_data_o` and `rd_flag_o`.
- R8: A write whose group ends above bit `NUM_BITS`−1, issued with neither `clr_i` nor `set_i`, leaves the register unchanged. In that case `wr_err_o` is 1 for exactly the following cycle, and at all other times it is 0.
- R9: While `rst_ni` is low, `pred_o` is all zeros and `wr_err_o` is 0.
- R10: A write issued in the same cycle as `clr_i` or `set_i` is ignored, and it raises no write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear all flags |
| set_i | input | 1 | Set all flags |
| esize_i | input | 2 | Element size code: 0=1, 1=2, 2=4, 3=8 bytes |
| wr_i | input | 1 | Raw element write strobe |
| wr_idx_i | input | $clog2(NUM_BITS) | Element index for the write |
| wr_data_i | input | 8 | Raw write value, LSB goes to the group base |
| rd_idx_i | input | $clog2(NUM_BITS) | Element index for the read |
| rd_data_o | output | 8 | Raw element group, right-aligned |
| rd_flag_o | output | 1 | Truth value of the read element |
| rd_err_o | output | 1 | Read group out of range |
| wr_err_o | output | 1 | Previous cycle's write was rejected |
| pred_o | output | NUM_BITS | Whole register value |

## Verification
The register value is visible at `pred_o` at every moment. A write that touches the wrong bits, uses the wrong bit order or uses the wrong group width therefore shows up at the first sampling point after the clock edge that performs it. A fault in address scaling or in the range check shows up on the read port in the same cycle, because the read path is purely combinational. It also shows up as a wrong `wr_err_o` pulse one cycle after the write. Sweeping every element size against every index in both layouts, with the register preset alternately to all ones and all zeros, brings each such fault to the ports within one cycle.

// File: rtl/pred_view_pkg.sv
package pred_view_pkg;

  typedef enum logic [1:0] {
    ESZ_1B = 2'd0,
    ESZ_2B = 2'd1,
    ESZ_4B = 2'd2,
    ESZ_8B = 2'd3
  } esize_e;

  localparam int unsigned RAW_W = 8;

  // group width in bits for a given layout and element size code
  function automatic logic [3:0] group_width(input logic packed_mode, input logic [1:0] code);
    if (packed_mode) return 4'd1;
    return 4'(4'd1 << code);
  endfunction

  function automatic logic [RAW_W-1:0] low_ones(input logic [3:0] w);
    logic [RAW_W:0] t;
    t = (9'd1 << w) - 9'd1;
    return t[RAW_W-1:0];
  endfunction

endpackage

// File: rtl/pred_elem_map.sv
module pred_elem_map
  import pred_view_pkg::*;
#(
  parameter int unsigned NUM_BITS = 64,
  parameter bit          PACKED   = 1'b0,
  parameter int unsigned IDX_W    = $clog2(NUM_BITS),
  parameter int unsigned POS_W    = IDX_W + 4
) (
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [1:0]          esize_i,
  output logic [POS_W-1:0]    base_o,
  output logic [3:0]          width_o,
  output logic                valid_o,
  output logic [NUM_BITS-1:0] mask_o
);

  logic [POS_W-1:0] idx_ext;
  logic [POS_W:0]   top_excl;
  logic [RAW_W-1:0] low;

  assign idx_ext = POS_W'(idx_i);

  generate
    if (PACKED) begin : g_packed
      logic unused_esize;
      assign unused_esize = ^esize_i;
      assign base_o  = idx_ext;
      assign width_o = 4'd1;
    end else begin : g_unpacked
      assign base_o  = idx_ext << esize_i;
      assign width_o = group_width(1'b0, esize_i);
    end
  endgenerate

  assign top_excl = {1'b0, base_o} + (POS_W+1)'(width_o);
  assign valid_o  = top_excl <= (POS_W+1)'(NUM_BITS);
  assign low      = low_ones(width_o);
  assign mask_o   = valid_o ? ({{(NUM_BITS-RAW_W){1'b0}}, low} << base_o) : '0;

endmodule

// File: rtl/pred_extract.sv
module pred_extract
  import pred_view_pkg::*;
#(
  parameter int unsigned NUM_BITS = 64,
  parameter int unsigned POS_W    = $clog2(NUM_BITS) + 4
) (
  input  logic [NUM_BITS-1:0] pred_i,
  input  logic [POS_W-1:0]    base_i,
  input  logic [3:0]          width_i,
  input  logic                valid_i,
  output logic [RAW_W-1:0]    data_o,
  output logic                flag_o,
  output logic                err_o
);

  logic [RAW_W-1:0] win;

  assign win    = RAW_W'(pred_i >> base_i);
  assign data_o = valid_i ? (win & low_ones(width_i)) : '0;
  assign flag_o = valid_i & win[0];
  assign err_o  = ~valid_i;

endmodule

// File: rtl/pred_store.sv
module pred_store #(
  parameter int unsigned NUM_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                set_i,
  input  logic                wr_i,
  input  logic                wr_ok_i,
  input  logic [NUM_BITS-1:0] wr_mask_i,
  input  logic [NUM_BITS-1:0] wr_bits_i,
  output logic [NUM_BITS-1:0] pred_o,
  output logic                wr_err_o
);

  logic [NUM_BITS-1:0] pred_q, pred_d;
  logic                err_d;

  always_comb begin
    pred_d = pred_q;
    err_d  = 1'b0;
    if (clr_i)       pred_d = '0;
    else if (set_i)  pred_d = '1;
    else if (wr_i) begin
      if (wr_ok_i) pred_d = (pred_q & ~wr_mask_i) | (wr_bits_i & wr_mask_i);
      else         err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q   <= '0;
      wr_err_o <= 1'b0;
    end else begin
      pred_q   <= pred_d;
      wr_err_o <= err_d;
    end
  end

  assign pred_o = pred_q;

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pred_o == '0));

  assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (pred_o == '1));

  assert_reject_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_ok_i && !clr_i && !set_i) |=> ($stable(pred_o) && wr_err_o));

  assert_outside_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && !set_i) |=> (((pred_o ^ $past(pred_o)) & ~$past(wr_mask_i)) == '0));

  assert_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || set_i || !wr_i) |=> !wr_err_o);

endmodule

// File: rtl/pred_reg_views.sv
module pred_reg_views
  import pred_view_pkg::*;
#(
  parameter int unsigned NUM_BITS = 64,
  parameter bit          PACKED   = 1'b0,
  localparam int unsigned IDX_W   = $clog2(NUM_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                set_i,
  input  logic [1:0]          esize_i,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [7:0]          wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [7:0]          rd_data_o,
  output logic                rd_flag_o,
  output logic                rd_err_o,
  output logic                wr_err_o,
  output logic [NUM_BITS-1:0] pred_o
);

  localparam int unsigned POS_W = IDX_W + 4;

  logic [POS_W-1:0]    wr_base, rd_base;
  logic [3:0]          wr_width, rd_width;
  logic                wr_ok, rd_ok;
  logic [NUM_BITS-1:0] wr_mask, rd_mask_unused, wr_bits;
  logic                unused_rd_mask;

  pred_elem_map #(.NUM_BITS(NUM_BITS), .PACKED(PACKED), .IDX_W(IDX_W), .POS_W(POS_W)) u_wr_map (
    .idx_i   (wr_idx_i),
    .esize_i (esize_i),
    .base_o  (wr_base),
    .width_o (wr_width),
    .valid_o (wr_ok),
    .mask_o  (wr_mask)
  );

  pred_elem_map #(.NUM_BITS(NUM_BITS), .PACKED(PACKED), .IDX_W(IDX_W), .POS_W(POS_W)) u_rd_map (
    .idx_i   (rd_idx_i),
    .esize_i (esize_i),
    .base_o  (rd_base),
    .width_o (rd_width),
    .valid_o (rd_ok),
    .mask_o  (rd_mask_unused)
  );

  assign unused_rd_mask = ^rd_mask_unused ^ ^wr_width;

  assign wr_bits = {{(NUM_BITS-RAW_W){1'b0}}, wr_data_i} << wr_base;

  pred_store #(.NUM_BITS(NUM_BITS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .set_i     (set_i),
    .wr_i      (wr_i),
    .wr_ok_i   (wr_ok),
    .wr_mask_i (wr_mask),
    .wr_bits_i (wr_bits),
    .pred_o    (pred_o),
    .wr_err_o  (wr_err_o)
  );

  pred_extract #(.NUM_BITS(NUM_BITS), .POS_W(POS_W)) u_extract (
    .pred_i  (pred_o),
    .base_i  (rd_base),
    .width_i (rd_width),
    .valid_i (rd_ok),
    .data_o  (rd_data_o),
    .flag_o  (rd_flag_o),
    .err_o   (rd_err_o)
  );

  assert_rd_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_data_o == 8'd0 && !rd_flag_o));

  assert_flag_is_low_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_err_o |-> (rd_flag_o == rd_data_o[0]));

endmodule

// File: tb/tb_pred_reg_views.sv
module tb_pred_reg_views;
  localparam int NB = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, set = 0, wr = 0;
  logic [1:0] es = 0;
  logic [IW-1:0] widx = 0, ridx = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rd_u, rd_p;
  logic fl_u, fl_p, re_u, re_p, we_u, we_p;
  logic [NB-1:0] pr_u, pr_p;
  logic [NB-1:0] m_u, m_p;
  logic exp_we_u, exp_we_p;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pred_reg_views #(.NUM_BITS(NB), .PACKED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .set_i(set), .esize_i(es),
    .wr_i(wr), .wr_idx_i(widx), .wr_data_i(wdata), .rd_idx_i(ridx),
    .rd_data_o(rd_u), .rd_flag_o(fl_u), .rd_err_o(re_u), .wr_err_o(we_u), .pred_o(pr_u));

  pred_reg_views #(.NUM_BITS(NB), .PACKED(1'b1)) dut_pk (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .set_i(set), .esize_i(es),
    .wr_i(wr), .wr_idx_i(widx), .wr_data_i(wdata), .rd_idx_i(ridx),
    .rd_data_o(rd_p), .rd_flag_o(fl_p), .rd_err_o(re_p), .wr_err_o(we_p), .pred_o(pr_p));

  function automatic int gw(input bit pk, input int e);
    return pk ? 1 : (1 << e);
  endfunction

  function automatic bit in_rng(input bit pk, input int e, input int i);
    return (i * gw(pk, e) + gw(pk, e)) <= NB;
  endfunction

  function automatic logic [NB-1:0] mwrite(input logic [NB-1:0] old, input bit pk,
                                           input int e, input int i, input logic [7:0] d);
    logic [NB-1:0] r = old;
    if (!in_rng(pk, e, i)) return old;
    for (int k = 0; k < gw(pk, e); k++) r[i*gw(pk, e)+k] = d[k];
    return r;
  endfunction

  function automatic logic [7:0] mread(input logic [NB-1:0] v, input bit pk,
                                       input int e, input int i);
    logic [7:0] r = 8'd0;
    if (!in_rng(pk, e, i)) return 8'd0;
    for (int k = 0; k < gw(pk, e); k++) r[k] = v[i*gw(pk, e)+k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // apply current inputs for one edge, update models, check at the following negedge
  task automatic tick();
    logic ovr = clr | set;
    if (clr) begin m_u = '0; m_p = '0; end
    else if (set) begin m_u = '1; m_p = '1; end
    else if (wr) begin
      m_u = mwrite(m_u, 1'b0, es, widx, wdata);
      m_p = mwrite(m_p, 1'b1, es, widx, wdata);
    end
    exp_we_u = wr && !ovr && !in_rng(1'b0, es, widx);
    exp_we_p = wr && !ovr && !in_rng(1'b1, es, widx);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R4/R2 unpacked register", pr_u, m_u);
    chk("R4/R1 packed register", pr_p, m_p);
    chk("R8 wr_err unpacked", we_u, exp_we_u);
    chk("R8 wr_err packed", we_p, exp_we_p);
  endtask

  task automatic read_sweep();
    for (int i = 0; i < NB; i++) begin
      ridx = i[IW-1:0];
      #1;
      chk("R3/R2 rd_data unpacked", rd_u, mread(m_u, 1'b0, es, i));
      chk("R3 rd_flag unpacked", fl_u, mread(m_u, 1'b0, es, i) & 8'd1);
      chk("R7 rd_err unpacked", re_u, !in_rng(1'b0, es, i));
      chk("R3/R1 rd_data packed", rd_p, mread(m_p, 1'b1, es, i));
      chk("R1 rd_flag packed", fl_p, m_p[i]);
      chk("R7 rd_err packed", re_p, 1'b0);
    end
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    m_u = '0; m_p = '0;
    #23;
    chk("R9 reset pred unpacked", pr_u, 0);
    chk("R9 reset pred packed", pr_p, 0);
    chk("R9 reset wr_err", {we_u, we_p}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R6 with R10: write of zeros alongside set is ignored
    set = 1; wr = 1; widx = 0; wdata = 8'h00;
    tick();
    // R5: clear wins over set and write
    clr = 1; set = 1; wr = 1; wdata = 8'hFF;
    tick();
    clr = 0; set = 0; wr = 0;
    tick();
    for (int e = 0; e < 4; e++) begin
      es = e[1:0];
      clr = (e % 2 == 1); set = (e % 2 == 0);
      tick();
      clr = 0; set = 0;
      read_sweep();
      for (int i = 0; i < NB; i++) begin
        wr = 1; widx = i[IW-1:0];
        wdata = 8'((i * 37 + e * 11 + 5) ^ 8'hA5);
        tick();
      end
      wr = 0;
      tick();
      read_sweep();
    end
    // R8: rejected write leaves register intact, error for one cycle only
    es = 2'd3; wr = 1; widx = 4'd2; wdata = 8'h00;
    tick();
    wr = 0;
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule